// File: doc/BRIEF.md
# Packed Vector Element Register Writer

This block takes a stream of vector results and stores them, packed back to back, into a bank of 64-bit scalar registers. The first register written is a base register chosen at start. Element 0 occupies the lowest bits of that register. Each later element occupies the next higher slot. When a register is full, packing carries on at bit 0 of the register numbered one higher. Elements can be 8, 16, 32 or 64 bits wide. A predicate mask selects which elements are really stored.

The register bank has one write enable per byte. A partial update of a register therefore changes only the bytes it targets and never reads the old contents. Elements that land in the same register are merged into one write with the combined byte enables. The write goes out when the register fills or when the last element arrives. A combinational read port lets the user inspect any register.

To start an operation, pulse `start` with the base register, the width code, the vector length and the mask. Then feed elements on a valid/ready stream. Watch for the one-cycle `done` pulse.

Top module: `vec_pack_writer`

## Requirements
- R1: Element k is stored at byte position k*S counted from byte 0 of the base register, where S is the element size in bytes. Byte position p lands in register base+p/8, at bits 8*(p mod 8) and upward.
- R2: With 16-bit elements (width code 1) and a vector length of 5, elements 0 to 3 fill the base register. Element 4 writes only bits 15:0 of register base+1, and bits 63:16 of that register keep their old value.
- R3: A register write changes only the bytes covered by enabled elements of the current operation. Every other byte of every register keeps its old value.
- R4: Mask bit k controls element k. When it is 0, the element still takes up its slot and is consumed from the stream, but none of its bytes are written. With 8-bit elements, each mask bit governs exactly one byte.
- R5: The 2-bit width code selects the element size: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits, 3 for 64 bits. Only the low S bytes of `elemData` are stored.
- R6: An enabled byte whose target register number exceeds 31 is discarded, and packing never wraps around to register 0. `overflow` goes to 1 when such a byte is discarded. It holds its value until the next accepted start, which clears it. Bytes of predicated-off elements never set it.
- R7: An accepted start with a vector length of 0 raises `done` in the cycle after the start edge and writes no register.
- R8: A `start` pulse while `busy` is 1 is ignored. The operation in progress completes with its original parameters.
- R9: After the clock edge that accepts the last element, `done` is 0 for one cycle and then 1 for exactly one cycle. At that point all results can be read on the read port.
- R10: `elemReady` is 1 only while elements are being collected. After reset, `busy`, `done`, `overflow` and `elemReady` are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| baseReg | input | 5 | First register to be written |
| elemWidth | input | 2 | Element size code (0:8, 1:16, 2:32, 3:64 bits) |
| vecLen | input | 7 | Number of elements, 0 to 64 |
| predMask | input | 64 | Bit k enables element k |
| elemValid | input | 1 | Element data is present |
| elemData | input | 64 | Element value, in the low bits |
| elemReady | output | 1 | Block accepts an element this cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | An enabled byte fell past register 31 |
| rdAddr | input | 5 | Read port register number |
| rdData | output | 64 | Read port data |

## Verification
Two things can happen in the same cycle: the block accepts an element, and a new `start` pulse arrives carrying different parameters. The bench provokes this on purpose. While streaming, it raises `start` on random cycles, with a random base, width, length and mask, including on the cycle where an element is accepted. It judges the outcome by comparing all 32 registers and `overflow` against a model that uses only the original parameters. A second overlap is the last element also filling its register, so that both flush reasons meet in one write. Random lengths and offsets make this frequent, and the `done` timing and the register contents are checked each time.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } elem_width_e;

  // strobes from the sequencer to the packing datapath
  typedef struct packed {
    logic load;      // capture a new operation
    logic accept;    // an element is taken this cycle
    logic lastElem;  // the accepted element is the final one
  } vpw_ctl_t;

endpackage

// File: rtl/vpw_control.sv
module vpw_control
  import vpw_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = $clog2(MAX_VL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vecLen,
  input  logic            elemValid,
  output logic            elemReady,
  output logic            busy,
  output logic            done,
  output vpw_ctl_t        ctl,
  output logic [IDXW-1:0] elemIdx
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;

  seq_state_e     state;
  logic [VLW-1:0] vlReg;
  logic [VLW-1:0] elemCnt;
  logic [VLW-1:0] vlClamped;

  always_comb begin
    vlClamped = (vecLen > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vecLen;
  end

  always_comb begin
    ctl.load     = (state == ST_IDLE) && start;
    ctl.accept   = (state == ST_RUN) && elemValid;
    ctl.lastElem = ctl.accept && (elemCnt == vlReg - 1'b1);
  end

  assign elemIdx   = elemCnt[IDXW-1:0];
  assign elemReady = (state == ST_RUN);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vlReg   <= '0;
      elemCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            vlReg   <= vlClamped;
            elemCnt <= '0;
            state   <= (vlClamped == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (ctl.accept) begin
            elemCnt <= elemCnt + 1'b1;
            if (ctl.lastElem) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vpw_datapath.sv
module vpw_datapath
  import vpw_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int REG_BYTES = 8,
  parameter int MAX_VL    = 64,
  localparam int REG_W = 8 * REG_BYTES,
  localparam int AW    = $clog2(NUM_REGS),
  localparam int IDXW  = $clog2(MAX_VL),
  localparam int OFFW  = $clog2(REG_BYTES),
  localparam int PTRW  = $clog2(NUM_REGS + MAX_VL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  vpw_ctl_t             ctl,
  input  logic [IDXW-1:0]      elemIdx,
  input  logic [AW-1:0]        baseReg,
  input  logic [1:0]           elemWidth,
  input  logic [MAX_VL-1:0]    predMask,
  input  logic [REG_W-1:0]     elemData,
  output logic                 wrEn,
  output logic [AW-1:0]        wrAddr,
  output logic [REG_W-1:0]     wrData,
  output logic [REG_BYTES-1:0] wrBe,
  output logic                 overflow
);

  localparam logic [OFFW:0] FULL_BYTES = (OFFW + 1)'(REG_BYTES);

  elem_width_e          cfgWidth;
  logic [MAX_VL-1:0]    cfgMask;
  logic [PTRW-1:0]      regPtr;
  logic [OFFW-1:0]      byteOff;
  logic [REG_W-1:0]     accData;
  logic [REG_BYTES-1:0] accBe;

  logic [OFFW:0]        sizeBytes;
  logic [REG_BYTES-1:0] laneBits;
  logic [REG_W-1:0]     dataMask;
  logic                 predOn;
  logic [REG_BYTES-1:0] elemBe;
  logic [REG_W-1:0]     placed;
  logic [REG_W-1:0]     mergedData;
  logic [REG_BYTES-1:0] mergedBe;
  logic                 endOfReg;
  logic                 doFlush;
  logic                 inRange;

  always_comb begin
    case (cfgWidth)
      EW8:     sizeBytes = (OFFW + 1)'(1);
      EW16:    sizeBytes = (OFFW + 1)'(2);
      EW32:    sizeBytes = (OFFW + 1)'(4);
      default: sizeBytes = (OFFW + 1)'(8);
    endcase
  end

  // byte lanes covered by one element, and the matching bit mask
  for (genvar b = 0; b < REG_BYTES; b++) begin : g_lane
    assign laneBits[b]         = (b < int'(sizeBytes));
    assign dataMask[b*8 +: 8]  = {8{laneBits[b]}};
  end

  always_comb begin
    predOn     = cfgMask[elemIdx];
    elemBe     = predOn ? (laneBits << byteOff) : '0;
    placed     = predOn ? ((elemData & dataMask) << {byteOff, 3'b000}) : '0;
    mergedData = accData | placed;
    mergedBe   = accBe | elemBe;
    endOfReg   = ({1'b0, byteOff} + sizeBytes) == FULL_BYTES;
    doFlush    = ctl.accept && (endOfReg || ctl.lastElem);
    inRange    = regPtr < PTRW'(NUM_REGS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgWidth <= EW8;
      cfgMask  <= '0;
      regPtr   <= '0;
      byteOff  <= '0;
      accData  <= '0;
      accBe    <= '0;
      wrEn     <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrBe     <= '0;
      overflow <= 1'b0;
    end else begin
      wrEn <= 1'b0;
      if (ctl.load) begin
        cfgWidth <= elem_width_e'(elemWidth);
        cfgMask  <= predMask;
        regPtr   <= PTRW'(baseReg);
        byteOff  <= '0;
        accData  <= '0;
        accBe    <= '0;
        overflow <= 1'b0;
      end else if (ctl.accept) begin
        byteOff <= byteOff + sizeBytes[OFFW-1:0];
        if (endOfReg) regPtr <= regPtr + 1'b1;
        if (doFlush) begin
          accData <= '0;
          accBe   <= '0;
          if (inRange) begin
            wrEn   <= 1'b1;
            wrAddr <= regPtr[AW-1:0];
            wrData <= mergedData;
            wrBe   <= mergedBe;
          end else if (|mergedBe) begin
            overflow <= 1'b1;
          end
        end else begin
          accData <= mergedData;
          accBe   <= mergedBe;
        end
      end
    end
  end

endmodule

// File: rtl/vpw_regfile.sv
module vpw_regfile #(
  parameter int NUM_REGS  = 32,
  parameter int REG_BYTES = 8,
  localparam int REG_W = 8 * REG_BYTES,
  localparam int AW    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [AW-1:0]        wrAddr,
  input  logic [REG_W-1:0]     wrData,
  input  logic [REG_BYTES-1:0] wrBe,
  input  logic [AW-1:0]        rdAddr,
  output logic [REG_W-1:0]     rdData
);

  logic [REG_W-1:0] regs [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[r] <= '0;
      end else if (wrEn && (wrAddr == AW'(r))) begin
        for (int b = 0; b < REG_BYTES; b++) begin
          if (wrBe[b]) regs[r][b*8 +: 8] <= wrData[b*8 +: 8];
        end
      end
    end
  end

  assign rdData = regs[rdAddr];

endmodule

// File: rtl/vec_pack_writer.sv
module vec_pack_writer
  import vpw_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int REG_BYTES = 8,
  parameter int MAX_VL    = 64,
  localparam int REG_W = 8 * REG_BYTES,
  localparam int AW    = $clog2(NUM_REGS),
  localparam int VLW   = $clog2(MAX_VL + 1),
  localparam int IDXW  = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     baseReg,
  input  logic [1:0]        elemWidth,
  input  logic [VLW-1:0]    vecLen,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              elemValid,
  input  logic [REG_W-1:0]  elemData,
  output logic              elemReady,
  output logic              busy,
  output logic              done,
  output logic              overflow,
  input  logic [AW-1:0]     rdAddr,
  output logic [REG_W-1:0]  rdData
);

  vpw_ctl_t             ctl;
  logic [IDXW-1:0]      elemIdx;
  logic                 wrEn;
  logic [AW-1:0]        wrAddr;
  logic [REG_W-1:0]     wrData;
  logic [REG_BYTES-1:0] wrBe;

  vpw_control #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vecLen    (vecLen),
    .elemValid (elemValid),
    .elemReady (elemReady),
    .busy      (busy),
    .done      (done),
    .ctl       (ctl),
    .elemIdx   (elemIdx)
  );

  vpw_datapath #(
    .NUM_REGS (NUM_REGS),
    .REG_BYTES(REG_BYTES),
    .MAX_VL   (MAX_VL)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .elemIdx   (elemIdx),
    .baseReg   (baseReg),
    .elemWidth (elemWidth),
    .predMask  (predMask),
    .elemData  (elemData),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .wrBe      (wrBe),
    .overflow  (overflow)
  );

  vpw_regfile #(
    .NUM_REGS (NUM_REGS),
    .REG_BYTES(REG_BYTES)
  ) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrBe   (wrBe),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

endmodule

// File: rtl/vpw_checker.sv
module vpw_checker #(
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [VLW-1:0] vecLen,
  input logic           busy,
  input logic           done,
  input logic           elemReady,
  input logic           overflow
);

  // R7
  vl_zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vecLen == '0) |=> done);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  ready_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elemReady |-> (busy && !done));

  // R8
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);

  // R6
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(overflow));

endmodule

bind vec_pack_writer vpw_checker #(.VLW(VLW)) u_vpw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .vecLen    (vecLen),
  .busy      (busy),
  .done      (done),
  .elemReady (elemReady),
  .overflow  (overflow)
);

// File: tb/vec_pack_writer_bench.sv
`timescale 1ns/1ps
module vec_pack_writer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  baseReg = '0;
  logic [1:0]  elemWidth = '0;
  logic [6:0]  vecLen = '0;
  logic [63:0] predMask = '0;
  logic        elemValid = 1'b0;
  logic [63:0] elemData = '0;
  logic        elemReady;
  logic        busy;
  logic        done;
  logic        overflow;
  logic [4:0]  rdAddr = '0;
  logic [63:0] rdData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [63:0] model [32];
  logic [63:0] elems [64];
  logic        expOvf;

  vec_pack_writer u_vec_pack_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .baseReg(baseReg),
    .elemWidth(elemWidth), .vecLen(vecLen), .predMask(predMask),
    .elemValid(elemValid), .elemData(elemData), .elemReady(elemReady),
    .busy(busy), .done(done), .overflow(overflow),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected effect of one operation, from R1/R4/R5/R6
  task automatic applyModel(input int base, input int w, input int vl, input logic [63:0] mask);
    int esz = 1 << w;
    expOvf = 1'b0;
    for (int k = 0; k < vl; k++) begin
      int pos = k * esz;
      int r   = base + pos / 8;
      int off = pos % 8;
      if (mask[k]) begin
        if (r < 32) begin
          for (int b = 0; b < esz; b++) model[r][(off + b)*8 +: 8] = elems[k][b*8 +: 8];
        end else begin
          expOvf = 1'b1;
        end
      end
    end
  endtask

  task automatic compareRegs(input string req);
    for (int r = 0; r < 32; r++) begin
      rdAddr = 5'(r);
      #0.1;
      check(req, rdData, model[r]);
    end
  endtask

  task automatic runOp(input string req, input int base, input int w, input int vl,
                       input logic [63:0] mask, input int gapPct, input bit inject);
    int got = 0;
    @(negedge clk);
    start = 1'b1; baseReg = 5'(base); elemWidth = 2'(w); vecLen = 7'(vl); predMask = mask;
    @(negedge clk);
    start = 1'b0;
    baseReg = 5'($urandom); elemWidth = 2'($urandom); vecLen = 7'($urandom % 65);
    predMask = {$urandom, $urandom};
    if (vl == 0) begin
      check({req, " R7 done after start"}, 64'(done), 64'd1);
      @(negedge clk);
      check({req, " R9 done one cycle"}, 64'(done), 64'd0);
    end else begin
      while (got < vl) begin
        elemValid = (($urandom % 100) >= gapPct);
        elemData  = {$urandom, $urandom};
        start     = inject && (($urandom % 3) == 0);
        if (elemValid && elemReady) begin
          elems[got] = elemData;
          got++;
        end
        @(negedge clk);
      end
      elemValid = 1'b0;
      start = 1'b0;
      check({req, " R9 done low after last"}, 64'(done), 64'd0);
      @(negedge clk);
      check({req, " R9 done pulse"}, 64'(done), 64'd1);
      @(negedge clk);
      check({req, " R9 done one cycle"}, 64'(done), 64'd0);
      check({req, " R10 ready idle"}, 64'(elemReady), 64'd0);
    end
    applyModel(base, w, vl, mask);
    compareRegs(req);
    check({req, " R6 overflow"}, 64'(overflow), 64'(expOvf));
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    for (int r = 0; r < 32; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", 64'(busy), 64'd0);
    check("R10 done", 64'(done), 64'd0);
    check("R10 overflow", 64'(overflow), 64'd0);
    check("R10 ready", 64'(elemReady), 64'd0);
    compareRegs("R10 regs zero");

    // R1 R5 fill every register with 64-bit elements
    runOp("R1 R5 fill64", 0, 3, 32, '1, 20, 0);
    // R2 16-bit, VL 5 spills four elements then one into bits 15:0
    runOp("R2 half VL5", 1, 1, 5, '1, 0, 0);
    // R4 8-bit, one byte per mask bit
    runOp("R4 bytes", 10, 0, 13, 64'h0000_0000_0000_1A5B, 30, 0);
    // R3 R4 32-bit partial with holes
    runOp("R3 words", 20, 2, 7, 64'h5A, 10, 0);
    // R6 past the last register sets overflow
    runOp("R6 overflow", 30, 3, 4, '1, 0, 0);
    // R6 predicated-off bytes past the end do not set it; start clears it
    runOp("R6 masked tail", 31, 3, 3, 64'h1, 0, 0);
    // R7 zero length
    runOp("R7 vl0", 5, 1, 0, '1, 0, 0);
    // R8 starts while busy are ignored
    runOp("R8 inject", 3, 0, 45, {$urandom, $urandom}, 25, 1);
    runOp("R1 R5 full 8-bit", 24, 0, 64, '1, 10, 1);

    // random mix
    for (int i = 0; i < 24; i++) begin
      int w  = int'($urandom % 4);
      int vl = int'($urandom % 65);
      runOp("R1 R3 R4 random", int'($urandom % 32), w, vl, {$urandom, $urandom},
            int'($urandom % 50), bit'($urandom % 2));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule